// File: doc/BRIEF.md
# UART Command and Status Controller

This block is the register-mapped control core of a simple serial channel. A processor reaches it through a plain synchronous register bus with a 64-byte window. Through that bus it can read a status byte, read the interrupt sources and set a mask over them, program two mode bytes through a self-advancing pointer, and write a command byte. The command byte carries three independent fields that act in one write: a miscellaneous reset action, a transmitter on/off control and a receiver on/off control.

The transmit side is a one-byte holding stage. A byte written to the transmit-buffer offset is handed to a downstream byte sink over a valid/ready handshake once the transmitter is enabled. The receive side keeps no storage of its own. An external receive buffer reports "holds data" and "full" to this block, and the block tells that buffer when it may accept data and when it must flush. One interrupt line combines the enabled sources. The receive source can be chosen, by a mode bit, to be either "data present" or "buffer full".

Writes to the clock-select and auxiliary-control offsets, and to any undecoded offset, are accepted and have no effect.

Top module: `uart_cmd_ctrl`

## Requirements
- R1: After reset the status byte reads 0x08, which means only transmitter-empty is set. The interrupt line, `tx_valid_o`, `rx_en_o` and `rx_flush_o` are low, both mode bytes are 0x00, and the mode pointer selects mode byte 1.
- R2: The first access (read or write) at offset 0x00 reaches mode byte 1. Every later access reaches mode byte 2, until a command with bits 6:4 = 1 moves the pointer back to mode byte 1.
- R3: A read at offset 0x04 returns the status byte. Bit0 is `rx_ready_i`, bit1 is `rx_full_i`, bit2 (transmitter ready) equals the transmitter enable, bit3 is transmitter-empty, and bits 7:4 read 0.
- R4: A read at offset 0x14 returns the interrupt sources. Bit0 equals status bit2. Bit1 equals `rx_full_i` when bit6 of mode byte 1 is set, and `rx_ready_i` otherwise. Bit2 is the break-change latch, and bits 7:3 read 0. A write at 0x14 loads the interrupt mask.
- R5: `irq_o` is high exactly when some bit of (interrupt sources AND mask) is set.
- R6: Command bits 3:2 control the transmitter and bits 1:0 control the receiver (`rx_en_o`). In each field, 1 enables, 2 disables, and 0 or 3 leave the enable unchanged.
- R7: Command bits 6:4 select one action. With 2 the receiver is disabled and `rx_flush_o` is high for exactly the cycle after the write. With 3 the transmitter is disabled and transmitter-empty is set, which drops any pending byte. With 5 the break latch is cleared. Values 0, 4, 6 and 7 do nothing. This action applies before the two enable fields of the same byte.
- R8: A write at offset 0x0C stores the byte and clears transmitter-empty. `tx_valid_o` is high while the transmitter is enabled and transmitter-empty is clear, with `tx_data_o` holding the byte. A cycle in which `tx_valid_o` and `tx_ready_i` are both high sets transmitter-empty. A byte written while the transmitter is disabled is offered once it is enabled.
- R9: A high `brk_evt_i` sets the break latch. If a break-clear command arrives in the same cycle, the set wins.
- R10: Writes at offsets 0x04, 0x10 and any undecoded offset change no state. Reads at 0x08, 0x0C and undecoded offsets return 0, and `bus_rdata` is 0 when no read is in progress.
- R11: When a transmit-buffer write coincides with a handshake on the previous byte, the new byte becomes pending and transmitter-empty stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset within the window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational during a read |
| rx_ready_i | input | 1 | Receive buffer holds data |
| rx_full_i | input | 1 | Receive buffer is full |
| rx_en_o | output | 1 | Receiver enabled; buffer may accept data |
| rx_flush_o | output | 1 | One-cycle receive buffer flush |
| brk_evt_i | input | 1 | Break condition change seen on the line |
| tx_valid_o | output | 1 | Transmit byte offered to the sink |
| tx_data_o | output | 8 | Transmit byte |
| tx_ready_i | input | 1 | Sink accepts the byte |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench keeps a behavioural model of the enables, the pointer, the break latch, the mask and the held byte. It compares every output on every cycle, so a wrong enable or empty flag shows up on `tx_valid_o`, `irq_o` or `rx_en_o` in the very next cycle. A wrong mode pointer or latch is hidden until the next read at 0x00 or 0x14. For that reason the sequences read those offsets right after each command that should move them. Stalled handshakes, coinciding write and accept, and commands that combine a reset with an enable are aimed at the ordering rules.

// File: rtl/uart_cc_pkg.sv
package uart_cc_pkg;
  localparam int WIN_AW = 6;
  localparam int BYTE_W = 8;

  localparam logic [WIN_AW-1:0] OFS_MODE = 6'h00;
  localparam logic [WIN_AW-1:0] OFS_STAT = 6'h04;
  localparam logic [WIN_AW-1:0] OFS_CMD  = 6'h08;
  localparam logic [WIN_AW-1:0] OFS_TXB  = 6'h0C;
  localparam logic [WIN_AW-1:0] OFS_IRQ  = 6'h14;

  typedef enum logic [2:0] {
    ACT_NONE   = 3'd0,
    ACT_PTR    = 3'd1,
    ACT_RXRST  = 3'd2,
    ACT_TXRST  = 3'd3,
    ACT_ERRCLR = 3'd4,
    ACT_BRKCLR = 3'd5,
    ACT_BRKON  = 3'd6,
    ACT_BRKOFF = 3'd7
  } act_e;

  typedef enum logic [1:0] {
    CTL_KEEP = 2'd0,
    CTL_ON   = 2'd1,
    CTL_OFF  = 2'd2,
    CTL_RSV  = 2'd3
  } ctl_e;

  typedef struct packed {
    logic ptr_rst;
    logic rx_rst;
    logic tx_rst;
    logic brk_clr;
    logic tx_on;
    logic tx_off;
    logic rx_on;
    logic rx_off;
  } cmd_t;
endpackage

// File: rtl/uart_cc_cmd.sv
module uart_cc_cmd
  import uart_cc_pkg::*;
(
  input  logic       we_i,
  input  logic [6:0] byte_i,
  output cmd_t       cmd_o
);
  act_e act;
  ctl_e txc;
  ctl_e rxc;

  always_comb begin
    act   = act_e'(byte_i[6:4]);
    txc   = ctl_e'(byte_i[3:2]);
    rxc   = ctl_e'(byte_i[1:0]);
    cmd_o = '0;
    if (we_i) begin
      cmd_o.ptr_rst = (act == ACT_PTR);
      cmd_o.rx_rst  = (act == ACT_RXRST);
      cmd_o.tx_rst  = (act == ACT_TXRST);
      cmd_o.brk_clr = (act == ACT_BRKCLR);
      cmd_o.tx_on   = (txc == CTL_ON);
      cmd_o.tx_off  = (txc == CTL_OFF);
      cmd_o.rx_on   = (rxc == CTL_ON);
      cmd_o.rx_off  = (rxc == CTL_OFF);
    end
  end
endmodule

// File: rtl/uart_cc_mode.sv
module uart_cc_mode #(
  parameter int MODE_N    = 2,
  parameter int DW        = 8,
  parameter int RXSEL_BIT = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          ptr_rst_i,
  output logic [DW-1:0] rdata_o,
  output logic          rxsel_o
);
  localparam int PW = (MODE_N > 1) ? $clog2(MODE_N) : 1;
  localparam logic [PW-1:0] LAST = PW'(MODE_N - 1);

  logic [PW-1:0] ptr_q, ptr_d;
  logic [DW-1:0] mr_q [MODE_N];
  logic [DW-1:0] mr_d [MODE_N];

  always_comb begin
    ptr_d = ptr_q;
    if (ptr_rst_i) ptr_d = '0;
    else if (acc_i && (ptr_q != LAST)) ptr_d = ptr_q + 1'b1;
    for (int i = 0; i < MODE_N; i++) mr_d[i] = mr_q[i];
    if (acc_i && wr_i) mr_d[ptr_q] = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      for (int i = 0; i < MODE_N; i++) mr_q[i] <= '0;
    end else begin
      ptr_q <= ptr_d;
      for (int i = 0; i < MODE_N; i++) mr_q[i] <= mr_d[i];
    end
  end

  assign rdata_o = mr_q[ptr_q];
  assign rxsel_o = mr_q[0][RXSEL_BIT];
endmodule

// File: rtl/uart_cc_tx.sv
module uart_cc_tx #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [DW-1:0] ldata_i,
  input  logic          tx_rst_i,
  input  logic          en_set_i,
  input  logic          en_clr_i,
  input  logic          ready_i,
  output logic          valid_o,
  output logic [DW-1:0] data_o,
  output logic          empty_o,
  output logic          en_o
);
  logic          en_q, en_d;
  logic          emp_q, emp_d;
  logic [DW-1:0] dat_q, dat_d;

  assign valid_o = en_q & ~emp_q;

  always_comb begin
    en_d = en_q;
    if (tx_rst_i) en_d = 1'b0;
    if (en_set_i) en_d = 1'b1;
    if (en_clr_i) en_d = 1'b0;
    emp_d = emp_q;
    if (valid_o && ready_i) emp_d = 1'b1;
    if (tx_rst_i) emp_d = 1'b1;
    if (load_i) emp_d = 1'b0;
    dat_d = load_i ? ldata_i : dat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      emp_q <= 1'b1;
      dat_q <= '0;
    end else begin
      en_q  <= en_d;
      emp_q <= emp_d;
      dat_q <= dat_d;
    end
  end

  assign data_o  = dat_q;
  assign empty_o = emp_q;
  assign en_o    = en_q;
endmodule

// File: rtl/uart_cmd_ctrl.sv
module uart_cmd_ctrl
  import uart_cc_pkg::*;
#(
  parameter int MODE_N    = 2,
  parameter int RXSEL_BIT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [WIN_AW-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              rx_ready_i,
  input  logic              rx_full_i,
  output logic              rx_en_o,
  output logic              rx_flush_o,
  input  logic              brk_evt_i,
  output logic              tx_valid_o,
  output logic [BYTE_W-1:0] tx_data_o,
  input  logic              tx_ready_i,
  output logic              irq_o
);
  logic wr_en, rd_en;
  logic mode_acc, cmd_we, txb_we, mask_we;
  cmd_t cmd;
  logic [BYTE_W-1:0] mode_rd;
  logic rxsel, tx_empty, tx_en;
  logic [BYTE_W-1:0] status, isr;

  logic              rxen_q, rxen_d;
  logic              flush_q, flush_d;
  logic              brk_q, brk_d;
  logic [BYTE_W-1:0] imr_q, imr_d;

  assign wr_en    = bus_sel & bus_wr;
  assign rd_en    = bus_sel & ~bus_wr;
  assign mode_acc = bus_sel & (bus_addr == OFS_MODE);
  assign cmd_we   = wr_en & (bus_addr == OFS_CMD);
  assign txb_we   = wr_en & (bus_addr == OFS_TXB);
  assign mask_we  = wr_en & (bus_addr == OFS_IRQ);

  uart_cc_cmd u_cmd (
    .we_i   (cmd_we),
    .byte_i (bus_wdata[6:0]),
    .cmd_o  (cmd)
  );

  uart_cc_mode #(.MODE_N(MODE_N), .DW(BYTE_W), .RXSEL_BIT(RXSEL_BIT)) u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_i     (mode_acc),
    .wr_i      (bus_wr),
    .wdata_i   (bus_wdata),
    .ptr_rst_i (cmd.ptr_rst),
    .rdata_o   (mode_rd),
    .rxsel_o   (rxsel)
  );

  uart_cc_tx #(.DW(BYTE_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (txb_we),
    .ldata_i  (bus_wdata),
    .tx_rst_i (cmd.tx_rst),
    .en_set_i (cmd.tx_on),
    .en_clr_i (cmd.tx_off),
    .ready_i  (tx_ready_i),
    .valid_o  (tx_valid_o),
    .data_o   (tx_data_o),
    .empty_o  (tx_empty),
    .en_o     (tx_en)
  );

  always_comb begin
    rxen_d = rxen_q;
    if (cmd.rx_rst) rxen_d = 1'b0;
    if (cmd.rx_on)  rxen_d = 1'b1;
    if (cmd.rx_off) rxen_d = 1'b0;
    flush_d = cmd.rx_rst;
    brk_d = brk_q;
    if (cmd.brk_clr) brk_d = 1'b0;
    if (brk_evt_i)   brk_d = 1'b1;
    imr_d = mask_we ? bus_wdata : imr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxen_q  <= 1'b0;
      flush_q <= 1'b0;
      brk_q   <= 1'b0;
      imr_q   <= '0;
    end else begin
      rxen_q  <= rxen_d;
      flush_q <= flush_d;
      brk_q   <= brk_d;
      imr_q   <= imr_d;
    end
  end

  assign status = {4'b0000, tx_empty, tx_en, rx_full_i, rx_ready_i};
  assign isr    = {5'b00000, brk_q, (rxsel ? rx_full_i : rx_ready_i), tx_en};
  assign irq_o  = |(isr & imr_q);

  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      case (bus_addr)
        OFS_MODE: bus_rdata = mode_rd;
        OFS_STAT: bus_rdata = status;
        OFS_IRQ:  bus_rdata = isr;
        default:  bus_rdata = '0;
      endcase
    end
  end

  assign rx_en_o    = rxen_q;
  assign rx_flush_o = flush_q;
endmodule

// File: rtl/uart_cc_chk.sv
module uart_cc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_sel,
  input logic       bus_wr,
  input logic [5:0] bus_addr,
  input logic [7:0] bus_wdata,
  input logic       rx_flush_o,
  input logic       tx_valid_o,
  input logic [7:0] tx_data_o,
  input logic       tx_ready_i,
  input logic       irq_o
);
  // R5
  mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == 6'h14 && bus_wdata == 8'h00) |=> !irq_o);

  // R8
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_o && !tx_ready_i && !bus_sel) |=> (tx_valid_o && $stable(tx_data_o)));

  // R8
  tx_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_o && tx_ready_i && !(bus_sel && bus_wr && bus_addr == 6'h0C)) |=> !tx_valid_o);

  // R7
  rx_flush_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush_o |-> $past(bus_sel && bus_wr && bus_addr == 6'h08 && bus_wdata[6:4] == 3'd2));

  // R6
  tx_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == 6'h08 && bus_wdata[3:2] == 2'd2) |=> !tx_valid_o);
endmodule

bind uart_cmd_ctrl uart_cc_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_sel    (bus_sel),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .rx_flush_o (rx_flush_o),
  .tx_valid_o (tx_valid_o),
  .tx_data_o  (tx_data_o),
  .tx_ready_i (tx_ready_i),
  .irq_o      (irq_o)
);

// File: tb/sim_uart_cmd_ctrl.sv
`timescale 1ns/1ps
module sim_uart_cmd_ctrl;
  localparam int CLK_NS = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       rx_ready_i = 1'b0, rx_full_i = 1'b0, brk_evt_i = 1'b0, tx_ready_i = 1'b0;
  logic       rx_en_o, rx_flush_o, tx_valid_o, irq_o;
  logic [7:0] tx_data_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  string phase = "R1 reset";

  // reference state
  int mr[2];
  int ptr, imr, tb;
  bit txen, txemp, rxen, flush, brk;

  always #(CLK_NS/2) clk = ~clk;

  uart_cmd_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_ready_i(rx_ready_i), .rx_full_i(rx_full_i), .rx_en_o(rx_en_o),
    .rx_flush_o(rx_flush_o), .brk_evt_i(brk_evt_i), .tx_valid_o(tx_valid_o),
    .tx_data_o(tx_data_o), .tx_ready_i(tx_ready_i), .irq_o(irq_o)
  );

  function automatic int isr_val();
    int rxi;
    rxi = ((mr[0] >> 6) & 1) ? int'(rx_full_i) : int'(rx_ready_i);
    return (int'(brk) << 2) | (rxi << 1) | int'(txen);
  endfunction

  function automatic int rd_exp();
    if (!(bus_sel && !bus_wr)) return 0;
    case (bus_addr)
      6'h00: return mr[ptr];
      6'h04: return (int'(txemp) << 3) | (int'(txen) << 2) | (int'(rx_full_i) << 1) | int'(rx_ready_i);
      6'h14: return isr_val();
      default: return 0;
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s [%s] at %0t: actual %0h expected %0h", tag, phase, $time, act, exp);
    end
  endtask

  // model update
  always @(posedge clk) begin
    if (!rst_n) begin
      mr[0] = 0; mr[1] = 0; ptr = 0; imr = 0; tb = 0;
      txen = 0; txemp = 1; rxen = 0; flush = 0; brk = 0;
    end else begin
      bit hs;
      hs = txen && !txemp && tx_ready_i;
      flush = 0;
      if (hs) txemp = 1;
      if (bus_sel && bus_addr == 6'h00) begin
        if (bus_wr) mr[ptr] = bus_wdata;
        if (ptr < 1) ptr++;
      end
      if (bus_sel && bus_wr) begin
        case (bus_addr)
          6'h08: begin
            case (bus_wdata[6:4])
              3'd1: ptr = 0;
              3'd2: begin rxen = 0; flush = 1; end
              3'd3: begin txen = 0; txemp = 1; end
              3'd5: brk = 0;
              default: ;
            endcase
            if (bus_wdata[3:2] == 2'd1) txen = 1;
            if (bus_wdata[3:2] == 2'd2) txen = 0;
            if (bus_wdata[1:0] == 2'd1) rxen = 1;
            if (bus_wdata[1:0] == 2'd2) rxen = 0;
          end
          6'h0C: begin tb = bus_wdata; txemp = 0; end
          6'h14: imr = bus_wdata;
          default: ;
        endcase
      end
      if (brk_evt_i) brk = 1;
    end
  end

  // compare every cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R5 irq", irq_o, ((isr_val() & imr) != 0) ? 1 : 0);
      chk("R8 tx_valid", tx_valid_o, (txen && !txemp) ? 1 : 0);
      if (txen && !txemp) chk("R8 tx_data", tx_data_o, tb);
      chk("R6 rx_en", rx_en_o, rxen);
      chk("R7 rx_flush", rx_flush_o, flush);
      chk(bus_addr == 6'h00 ? "R2 mode read" : bus_addr == 6'h04 ? "R3 status" :
          bus_addr == 6'h14 ? "R4 isr" : "R10 rdata", bus_rdata, rd_exp());
    end
  end

  task automatic cyc(bit s, bit w, logic [5:0] a, logic [7:0] d);
    @(negedge clk); #1;
    bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
  endtask
  task automatic wr(logic [5:0] a, logic [7:0] d); cyc(1, 1, a, d); endtask
  task automatic rd(logic [5:0] a); cyc(1, 0, a, 8'h00); endtask
  task automatic idle(int n); for (int i = 0; i < n; i++) cyc(0, 0, 6'h00, 8'h00); endtask

  initial begin
    repeat (3) @(negedge clk);
    #2 rst_n = 1'b1;
    // R1: reset values seen through the status read
    phase = "R1 reset";
    rd(6'h04); rd(6'h14); idle(1);

    phase = "R2 pointer";
    rd(6'h00); rd(6'h00); wr(6'h00, 8'h11); rd(6'h00);
    wr(6'h08, 8'h10); wr(6'h00, 8'h40); rd(6'h00); wr(6'h08, 8'h10); rd(6'h00); rd(6'h00);

    phase = "R3 status";
    rx_ready_i = 1; rd(6'h04); rx_full_i = 1; rd(6'h04); rx_ready_i = 0; rd(6'h04);
    rx_full_i = 0; rd(6'h04);

    phase = "R4 R5 irq source";
    wr(6'h14, 8'h02);
    rx_ready_i = 1; rd(6'h14); rx_full_i = 1; rd(6'h14); rx_ready_i = 0; rx_full_i = 0; rd(6'h14);
    wr(6'h08, 8'h10); wr(6'h00, 8'h00);
    rx_ready_i = 1; rd(6'h14); rx_ready_i = 0; rd(6'h14);
    wr(6'h14, 8'h01); wr(6'h08, 8'h04); rd(6'h14); wr(6'h14, 8'hF8); rd(6'h14);

    phase = "R6 enables";
    wr(6'h08, 8'h05); rd(6'h04); wr(6'h08, 8'h0F); rd(6'h04); wr(6'h08, 8'h00); rd(6'h04);
    wr(6'h08, 8'h0A); rd(6'h04); wr(6'h08, 8'h01); rd(6'h04);

    phase = "R8 transmit hold";
    wr(6'h0C, 8'h3C); rd(6'h04); idle(2);
    wr(6'h08, 8'h04); idle(3); tx_ready_i = 1; idle(1); tx_ready_i = 0; rd(6'h04);
    wr(6'h0C, 8'hA5); idle(4); tx_ready_i = 1; idle(2); tx_ready_i = 0;

    phase = "R11 write during accept";
    wr(6'h0C, 8'h01); tx_ready_i = 1; wr(6'h0C, 8'h02); wr(6'h0C, 8'h03); idle(1); tx_ready_i = 0;
    rd(6'h04);

    phase = "R7 misc actions";
    wr(6'h08, 8'h20); rd(6'h04); idle(1);
    wr(6'h08, 8'h01); wr(6'h08, 8'h21); idle(1);
    wr(6'h0C, 8'h77); idle(1); wr(6'h08, 8'h30); rd(6'h04);
    wr(6'h08, 8'h04); wr(6'h0C, 8'h88); wr(6'h08, 8'h34); rd(6'h04); idle(1);
    wr(6'h08, 8'h40); wr(6'h08, 8'h60); wr(6'h08, 8'h70); rd(6'h04);
    tx_ready_i = 1; idle(1); tx_ready_i = 0;

    phase = "R9 break latch";
    wr(6'h14, 8'h04);
    brk_evt_i = 1; idle(1); brk_evt_i = 0; rd(6'h14);
    wr(6'h08, 8'h50); rd(6'h14);
    brk_evt_i = 1; wr(6'h08, 8'h50); brk_evt_i = 0; rd(6'h14);
    wr(6'h08, 8'h50); rd(6'h14);

    phase = "R10 ignored offsets";
    wr(6'h04, 8'hFF); wr(6'h10, 8'hFF); wr(6'h18, 8'hFF); wr(6'h3C, 8'hFF);
    rd(6'h04); rd(6'h14); rd(6'h08); rd(6'h0C); rd(6'h20); rd(6'h00);
    idle(2);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog [%s]: actual hung expected finish", phase);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule